// File: doc/BRIEF.md
# Interrupt Pin Request and EOI Tracker

This block holds the per-pin request state for a bank of interrupt input lines. Each pin has a redirection entry with a polarity bit, a trigger mode, a mask bit, a vector and a remote-IRR flag. The block turns raw pin levels into delivery requests. It picks one pin per cycle, always the lowest-numbered one that is ready, and reports that pin's index on the delivery port. For level-triggered pins it also asks the table to set the remote-IRR flag.

The remote-IRR flags are stored in the redirection table outside this block. They arrive on `rirr_i`, and the block changes them only through its set and clear pulses. An end-of-interrupt message carries a vector. The block searches the vectors for the lowest-numbered matching pin and issues a clear pulse for it. Once the flag is clear, a level pin that is still asserted is served again by the normal pin selection.

Top module: `irq_req_eoi_tracker`

## Requirements
- R1: The effective level of a pin is its input XOR its polarity bit. An input driven to 0 with polarity 1 counts as asserted.
- R2: An edge-triggered pin whose effective level rises is delivered exactly once. The delivery comes in the cycle after the rise, and `rirr_set_o` stays 0 for it. Holding the level high brings no further delivery.
- R3: An edge-triggered pin that rises while masked is discarded. It is not delivered, even if the mask is cleared later while the input stays high.
- R4: An unmasked level-triggered pin with remote IRR clear is delivered in the cycle after its effective level rises. `rirr_set_o` is 1 in that same cycle.
- R5: A level-triggered pin whose remote IRR is set is not delivered.
- R6: A masked level-triggered pin that is asserted stays pending. It is delivered in the same cycle its mask is cleared, provided it is still asserted.
- R7: When `eoi_valid_i` is 1, `rirr_clr_o` pulses in that same cycle. `rirr_clr_pin_o` gives the lowest-numbered pin whose 8-bit vector equals `eoi_vec_i`. If no vector matches, no output changes.
- R8: After a matching EOI, a level pin that is still asserted and unmasked is delivered in the next cycle, with `rirr_set_o` set again.
- R9: At most one pin is delivered per cycle. Pins that become ready in the same cycle are delivered in ascending index order, one per cycle.
- R10: In a cycle that carries a matching EOI, no pin is delivered. A pin that is ready in that cycle is delivered in the following cycle.
- R11: During reset all outputs are 0.
- R12: When a pin's effective level is 0, its request is cleared. A level pin that has dropped is not redelivered after its EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | NPINS | Raw interrupt input levels |
| pol_i | input | NPINS | Polarity bit per pin (1 = active low) |
| lvl_trig_i | input | NPINS | Trigger mode per pin (1 = level, 0 = edge) |
| mask_i | input | NPINS | Mask bit per pin |
| rirr_i | input | NPINS | Remote-IRR flag per pin, from the table |
| vec_i | input | NPINS*VEC_W | Vector per pin; pin p occupies bits [p*VEC_W +: VEC_W] |
| eoi_valid_i | input | 1 | End-of-interrupt message present |
| eoi_vec_i | input | VEC_W | Vector carried by the EOI |
| dlv_valid_o | output | 1 | Delivery request this cycle |
| dlv_pin_o | output | IDX_W | Index of the pin being delivered |
| rirr_set_o | output | 1 | Set remote IRR of `dlv_pin_o` |
| rirr_clr_o | output | 1 | Clear remote IRR of `rirr_clr_pin_o` |
| rirr_clr_pin_o | output | IDX_W | Pin whose remote IRR is cleared |

## Verification
Each pin's level is registered once. A delivery caused by a pin change therefore appears one cycle after the input moves. EOI clear pulses and deliveries caused by an unmask are combinational, so they appear in the same cycle as the stimulus. A redelivery after an EOI appears one cycle later, because the table's remote-IRR flag must clear first.

The bench drives its stimulus on the falling edge. Each time it drives, it tags the expected result with the exact cycle in which that result is due. A monitor samples the outputs shortly after every falling edge and compares them with the queue entry for that cycle. Any output outside an expected cycle counts as a failure.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned VEC_W_DEF = 8;
  localparam int unsigned NPINS_DEF = 24;
endpackage

// File: rtl/irq_pin_req.sv
module irq_pin_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  input  logic lvl_trig_i,
  input  logic mask_i,
  input  logic rirr_i,
  input  logic served_i,
  output logic pend_o
);
  logic eff, lvl_q, irr_q, irr_d;

  assign eff = pin_i ^ pol_i;

  always_comb begin
    if (!eff)            irr_d = 1'b0;
    else if (lvl_trig_i) irr_d = 1'b1;
    else                 irr_d = (irr_q | ~lvl_q) & ~served_i;  // edge: set on rise, drop on service
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      irr_q <= 1'b0;
    end else begin
      lvl_q <= eff;
      irr_q <= irr_d;
    end
  end

  // masked edge pins are still serviced so that their request is dropped
  assign pend_o = lvl_trig_i ? (irr_q & ~mask_i & ~rirr_i) : irr_q;
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int unsigned W  = 24,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_eoi_tracker.sv
module irq_req_eoi_tracker #(
  parameter int unsigned NPINS = irq_trk_pkg::NPINS_DEF,
  parameter int unsigned VEC_W = irq_trk_pkg::VEC_W_DEF,
  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPINS-1:0]       pin_lvl_i,
  input  logic [NPINS-1:0]       pol_i,
  input  logic [NPINS-1:0]       lvl_trig_i,
  input  logic [NPINS-1:0]       mask_i,
  input  logic [NPINS-1:0]       rirr_i,
  input  logic [NPINS*VEC_W-1:0] vec_i,
  input  logic                   eoi_valid_i,
  input  logic [VEC_W-1:0]       eoi_vec_i,
  output logic                   dlv_valid_o,
  output logic [IDX_W-1:0]       dlv_pin_o,
  output logic                   rirr_set_o,
  output logic                   rirr_clr_o,
  output logic [IDX_W-1:0]       rirr_clr_pin_o
);
  logic [NPINS-1:0] pend, eoi_hit, served;
  logic             grant_v, grant_en, eoi_v;
  logic [IDX_W-1:0] grant_idx, eoi_idx;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    irq_pin_req u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_lvl_i[p]),
      .pol_i      (pol_i[p]),
      .lvl_trig_i (lvl_trig_i[p]),
      .mask_i     (mask_i[p]),
      .rirr_i     (rirr_i[p]),
      .served_i   (served[p]),
      .pend_o     (pend[p])
    );
    assign eoi_hit[p] = eoi_valid_i && (vec_i[p*VEC_W +: VEC_W] == eoi_vec_i);
    assign served[p]  = grant_en && (grant_idx == IDX_W'(p));
  end

  irq_low_pick #(.W(NPINS), .IW(IDX_W)) u_eoi_pick (
    .req_i (eoi_hit),
    .vld_o (eoi_v),
    .idx_o (eoi_idx)
  );

  irq_low_pick #(.W(NPINS), .IW(IDX_W)) u_srv_pick (
    .req_i (pend),
    .vld_o (grant_v),
    .idx_o (grant_idx)
  );

  // a matching EOI owns the cycle; pin service waits one cycle
  assign grant_en       = grant_v && !eoi_v;
  assign dlv_valid_o    = grant_en && !mask_i[grant_idx];
  assign dlv_pin_o      = grant_idx;
  assign rirr_set_o     = dlv_valid_o && lvl_trig_i[grant_idx];
  assign rirr_clr_o     = eoi_v;
  assign rirr_clr_pin_o = eoi_idx;
endmodule

// File: rtl/irq_req_eoi_tracker_chk.sv
module irq_req_eoi_tracker_chk #(
  parameter int unsigned NPINS = 24,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NPINS-1:0]       lvl_trig_i,
  input logic [NPINS-1:0]       mask_i,
  input logic [NPINS-1:0]       rirr_i,
  input logic [NPINS*VEC_W-1:0] vec_i,
  input logic                   eoi_valid_i,
  input logic [VEC_W-1:0]       eoi_vec_i,
  input logic                   dlv_valid_o,
  input logic [IDX_W-1:0]       dlv_pin_o,
  input logic                   rirr_set_o,
  input logic                   rirr_clr_o,
  input logic [IDX_W-1:0]       rirr_clr_pin_o
);
  // R3
  dlv_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> !mask_i[dlv_pin_o]);
  // R4
  set_on_level_dlv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_set_o |-> dlv_valid_o && lvl_trig_i[dlv_pin_o]);
  // R5
  level_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && lvl_trig_i[dlv_pin_o] |-> !rirr_i[dlv_pin_o]);
  // R2
  edge_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && !lvl_trig_i[dlv_pin_o] |-> !rirr_set_o);
  // R7
  clr_needs_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_clr_o |-> eoi_valid_i && (vec_i[rirr_clr_pin_o*VEC_W +: VEC_W] == eoi_vec_i));
  // R10
  eoi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_clr_o |-> !dlv_valid_o);
  // R9
  pin_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (32'(dlv_pin_o) < NPINS));
endmodule

bind irq_req_eoi_tracker irq_req_eoi_tracker_chk #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lvl_trig_i     (lvl_trig_i),
  .mask_i         (mask_i),
  .rirr_i         (rirr_i),
  .vec_i          (vec_i),
  .eoi_valid_i    (eoi_valid_i),
  .eoi_vec_i      (eoi_vec_i),
  .dlv_valid_o    (dlv_valid_o),
  .dlv_pin_o      (dlv_pin_o),
  .rirr_set_o     (rirr_set_o),
  .rirr_clr_o     (rirr_clr_o),
  .rirr_clr_pin_o (rirr_clr_pin_o)
);

// File: tb/irq_req_eoi_tracker_tb.sv
`timescale 1ns/1ps
module irq_req_eoi_tracker_tb;
  localparam int N = 24;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] pin_lvl, pol, trig, mask, rirr_tb;
  logic [N*VW-1:0] vec;
  logic eoi_v;
  logic [VW-1:0] eoi_vec;
  logic dlv_v, rset, rclr;
  logic [IW-1:0] dlv_pin, clr_pin;

  always #2 clk = ~clk;

  irq_req_eoi_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_lvl_i(pin_lvl), .pol_i(pol), .lvl_trig_i(trig),
    .mask_i(mask), .rirr_i(rirr_tb), .vec_i(vec), .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_vec),
    .dlv_valid_o(dlv_v), .dlv_pin_o(dlv_pin), .rirr_set_o(rset), .rirr_clr_o(rclr),
    .rirr_clr_pin_o(clr_pin)
  );

  // redirection-table model of the remote-IRR flags
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rirr_tb <= '0;
    else begin
      if (rset) rirr_tb[dlv_pin] <= 1'b1;
      if (rclr) rirr_tb[clr_pin] <= 1'b0;
    end
  end

  typedef struct {int cyc; bit dv; int dp; bit st; bit cl; int cp; string req;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  function automatic void expect_at(int at, bit dv, int dp, bit st, bit cl, int cp, string r);
    exp_t e;
    e.cyc = at; e.dv = dv; e.dp = dp; e.st = st; e.cl = cl; e.cp = cp; e.req = r;
    q.push_back(e);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      if (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        checks++;
        bad = (e.cyc != cyc) || (dlv_v != e.dv) || (rset != e.st) || (rclr != e.cl)
              || (e.dv && int'(dlv_pin) != e.dp) || (e.cl && int'(clr_pin) != e.cp);
        if (bad) begin
          fails++;
          $display("FAIL %s cyc %0d: got dv=%0b pin=%0d set=%0b clr=%0b cpin=%0d exp cyc %0d dv=%0b pin=%0d set=%0b clr=%0b cpin=%0d",
                   e.req, cyc, dlv_v, dlv_pin, rset, rclr, clr_pin, e.cyc, e.dv, e.dp, e.st, e.cl, e.cp);
        end
      end else if (dlv_v || rset || rclr) begin
        checks++; fails++;
        $display("FAIL unexpected cyc %0d: got dv=%0b pin=%0d set=%0b clr=%0b cpin=%0d exp idle",
                 cyc, dlv_v, dlv_pin, rset, rclr, clr_pin);
      end
    end
    cyc++;
  end

  task automatic nxt(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int c;
    pin_lvl = '0; pol = '0; trig = '0; mask = '1; eoi_v = 1'b0; eoi_vec = '0;
    for (int p = 0; p < N; p++) vec[p*VW +: VW] = VW'(8'h20 + p);
    vec[10*VW +: VW] = 8'h50;
    vec[12*VW +: VW] = 8'h50;
    nxt(3);
    #1;
    checks++;  // R11 reset state
    if (dlv_v || rset || rclr) begin
      fails++;
      $display("FAIL R11: got dv=%0b set=%0b clr=%0b exp 0 0 0", dlv_v, rset, rclr);
    end
    nxt; rst_ni = 1'b1;
    nxt(2);

    // R2: edge pin 3
    mask[3] = 1'b0; pin_lvl[3] = 1'b1; c = cyc;
    expect_at(c, 0, 0, 0, 0, 0, "R2");
    expect_at(c + 1, 1, 3, 0, 0, 0, "R2");
    expect_at(c + 2, 0, 0, 0, 0, 0, "R2");
    expect_at(c + 3, 0, 0, 0, 0, 0, "R2");
    nxt(4); pin_lvl[3] = 1'b0; nxt(2);

    // R1: polarity on pin 5
    pin_lvl[5] = 1'b1; nxt(3);
    pol[5] = 1'b1; nxt;
    mask[5] = 1'b0; nxt;
    pin_lvl[5] = 1'b0; c = cyc;
    expect_at(c + 1, 1, 5, 0, 0, 0, "R1");
    nxt(3);

    // R3: masked edge pin 7
    pin_lvl[7] = 1'b1; nxt(2);
    mask[7] = 1'b0; c = cyc;
    expect_at(c, 0, 0, 0, 0, 0, "R3");
    expect_at(c + 1, 0, 0, 0, 0, 0, "R3");
    nxt(3);

    // R4 R5 R8 R12: level pin 9 (vector 0x29)
    trig[9] = 1'b1; mask[9] = 1'b0; nxt;
    pin_lvl[9] = 1'b1; c = cyc;
    expect_at(c + 1, 1, 9, 1, 0, 0, "R4");
    expect_at(c + 2, 0, 0, 0, 0, 0, "R5");
    expect_at(c + 3, 0, 0, 0, 0, 0, "R5");
    nxt(4);
    eoi_v = 1'b1; eoi_vec = 8'h29; c = cyc;
    expect_at(c, 0, 0, 0, 1, 9, "R7");
    expect_at(c + 1, 1, 9, 1, 0, 0, "R8");
    nxt; eoi_v = 1'b0; nxt(2);
    pin_lvl[9] = 1'b0; nxt;
    eoi_v = 1'b1; eoi_vec = 8'h29; c = cyc;
    expect_at(c, 0, 0, 0, 1, 9, "R7");
    expect_at(c + 1, 0, 0, 0, 0, 0, "R12");
    nxt; eoi_v = 1'b0; nxt(2);

    // R7: no match, then lowest of two matches
    eoi_v = 1'b1; eoi_vec = 8'h99; c = cyc;
    expect_at(c, 0, 0, 0, 0, 0, "R7");
    nxt; eoi_vec = 8'h50; c = cyc;
    expect_at(c, 0, 0, 0, 1, 10, "R7");
    nxt; eoi_v = 1'b0; nxt;

    // R9: simultaneous edges on 16 and 14
    mask[14] = 1'b0; mask[16] = 1'b0; nxt;
    pin_lvl[16] = 1'b1; pin_lvl[14] = 1'b1; c = cyc;
    expect_at(c + 1, 1, 14, 0, 0, 0, "R9");
    expect_at(c + 2, 1, 16, 0, 0, 0, "R9");
    expect_at(c + 3, 0, 0, 0, 0, 0, "R9");
    nxt(4);

    // R10: EOI collides with ready edge pin 20
    mask[20] = 1'b0; nxt;
    pin_lvl[20] = 1'b1; nxt;
    eoi_v = 1'b1; eoi_vec = 8'h29; c = cyc;
    expect_at(c, 0, 0, 0, 1, 9, "R10");
    expect_at(c + 1, 1, 20, 0, 0, 0, "R10");
    nxt; eoi_v = 1'b0; nxt(2);

    // R6: masked level pin 11 held, delivered on unmask
    trig[11] = 1'b1; nxt;
    pin_lvl[11] = 1'b1; c = cyc;
    expect_at(c + 1, 0, 0, 0, 0, 0, "R6");
    expect_at(c + 2, 0, 0, 0, 0, 0, "R6");
    nxt(3);
    mask[11] = 1'b0; c = cyc;
    expect_at(c, 1, 11, 1, 0, 0, "R6");
    expect_at(c + 1, 0, 0, 0, 0, 0, "R5");
    nxt(4);

    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL leftover: got %0d pending items exp 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule